// File: doc/BRIEF.md
# Dual Panel Flash Address Mapper

This block sits between the flash request paths and a two-panel flash array. It turns a logical program or boot address into a physical panel number and a byte offset inside that panel, once for the read path and once for the write/erase path. A configuration bit lets software exchange the two panels' program spaces. The program space still reads as one unbroken range. A second bit chooses whether the boot areas act as one joined image or as two separate boot sources.

The read path is a valid/ready stream. A read may run while a write or erase is busy, as long as the two touch different physical panels. A read aimed at the busy panel is back-pressured: `rd_ready` stays low and `rd_stall` stays high until `wr_active` falls. The requester must then hold `rd_valid` and `rd_addr` steady. The read transfers in the cycle where `rd_valid` and `rd_ready` are both high, and `rd_panel`/`rd_offset` in that cycle are the ones to use. The write path has no handshake: `wr_active` marks a program/erase in progress on `wr_addr`.

The address layout uses default parameters: 512 KB panels, 4 KB pages and 16 boot pages per panel. The most significant address bit selects the region (0 program, 1 boot). In physical offsets the top bit marks the boot area, which sits above the program area in each panel.

Top module: `flash_panel_mapper`

## Requirements
- R1: After reset the configuration is swap off and single boot. With no read offered, `rd_stall` and `rd_conflict` are low and `rd_ready` is high.
- R2: When address bit 20 is 0 (program region), bit 19 is the logical panel and bits 18:0 are the offset. With swap off, the physical panel equals the logical panel and `*_offset` is {1'b0, bits 18:0}.
- R3: With swap on, a program address maps to the other physical panel with the same offset. The logical program range stays contiguous, so the last byte of the lower half and the first byte of the upper half land in different panels.
- R4: When address bit 20 is 1 (boot region), bit 16 selects a boot half and bits 15:0 are the offset inside it. The physical offset is {1'b1, 3'b000, bits 15:0}. In single boot mode the panel equals bit 16 and swap has no effect.
- R5: In dual boot mode a boot address maps to panel bit16 XOR swap.
- R6: A boot address with any of bits 19:17 set raises `*_hole`. A read flagged as a hole never stalls and never conflicts.
- R7: A valid read whose physical panel differs from the panel of an active write has `rd_ready` high and `rd_stall` low.
- R8: A valid read that maps to the panel of an active write holds `rd_ready` low and `rd_stall` high until `wr_active` drops. In that cycle `rd_ready` rises and the read keeps the mapping it had while stalled.
- R9: `rd_conflict` pulses for exactly one cycle, the first cycle of each stalled episode.
- R10: `cfg_swap` and `cfg_dual_boot` are captured at each clock edge where `wr_active` is low and take effect from the next cycle. A change made while `wr_active` is high is held and applies in the cycle after `wr_active` falls.
- R11: The write address is mapped by the same rules and outputs `wr_panel`, `wr_offset` and `wr_hole`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_swap | input | 1 | Requested panel exchange for program (and dual boot) space |
| cfg_dual_boot | input | 1 | Requested boot mode: 1 dual, 0 single |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_addr | input | 21 | Logical read address |
| rd_panel | output | 1 | Physical panel of the read |
| rd_offset | output | 20 | Physical offset of the read within its panel |
| rd_hole | output | 1 | Read address falls in an unmapped boot gap |
| rd_stall | output | 1 | Read held because its panel is busy |
| rd_conflict | output | 1 | First cycle of a read/write panel collision |
| wr_active | input | 1 | Write or erase in progress |
| wr_addr | input | 21 | Logical write/erase address |
| wr_panel | output | 1 | Physical panel of the write |
| wr_offset | output | 20 | Physical offset of the write within its panel |
| wr_hole | output | 1 | Write address falls in an unmapped boot gap |

## Verification
A corrupted configuration register shows up on the next mapped address: the panel output for a program address flips, or a boot address lands in the wrong half. The bench sees this in the first cycle after a configuration change, and again right after a write ends. A wrong collision decision shows at once as `rd_ready` disagreeing with the panel comparison the bench makes on its own. A stuck edge register for the conflict pulse shows one cycle later, as a second pulse or a missing one.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef struct packed {
    logic swap;
    logic dual_boot;
  } fpm_cfg_t;
endpackage

// File: rtl/fpm_cfg_shadow.sv
module fpm_cfg_shadow
  import fpm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_active,
  input  logic     swap_req,
  input  logic     dual_req,
  output fpm_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (!wr_active) begin
      cfg.swap      <= swap_req;
      cfg.dual_boot <= dual_req;
    end
  end

  // R10: configuration frozen across any clock edge with a write in progress
  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_active |=> $stable(cfg));
endmodule

// File: rtl/fpm_addr_map.sv
module fpm_addr_map
  import fpm_pkg::*;
#(
  parameter int PANEL_AW = 19,
  parameter int BOOT_AW  = 16,
  localparam int AW      = PANEL_AW + 2,
  localparam int OFF_W   = PANEL_AW + 1,
  localparam int GAP_W   = PANEL_AW - BOOT_AW
) (
  input  logic [AW-1:0]    addr,
  input  fpm_cfg_t         cfg,
  output logic             panel,
  output logic [OFF_W-1:0] offset,
  output logic             hole
);
  logic boot_region;
  logic boot_half;

  always_comb begin
    boot_region = addr[AW-1];
    boot_half   = addr[BOOT_AW];
    if (!boot_region) begin
      panel  = addr[PANEL_AW] ^ cfg.swap;
      offset = {1'b0, addr[PANEL_AW-1:0]};
      hole   = 1'b0;
    end else begin
      panel  = cfg.dual_boot ? (boot_half ^ cfg.swap) : boot_half;
      offset = {1'b1, {GAP_W{1'b0}}, addr[BOOT_AW-1:0]};
      hole   = |addr[PANEL_AW:BOOT_AW+1];
    end
  end

  // R2/R4: the offset region marker follows the logical region
  always_comb begin
    a_r4_region_marker: assert (offset[OFF_W-1] == addr[AW-1]);
  end
endmodule

// File: rtl/fpm_live_arb.sv
module fpm_live_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_valid,
  input  logic rd_panel,
  input  logic rd_hole,
  input  logic wr_active,
  input  logic wr_panel,
  input  logic wr_hole,
  output logic rd_ready,
  output logic rd_stall,
  output logic rd_conflict
);
  logic collide;
  logic collide_q;

  always_comb begin
    collide     = rd_valid && wr_active && !rd_hole && !wr_hole
                  && (rd_panel == wr_panel);
    rd_ready    = !collide;
    rd_stall    = collide;
    rd_conflict = collide && !collide_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) collide_q <= 1'b0;
    else        collide_q <= collide;
  end

  // R9: the conflict marker only appears while a read is held
  a_r9_conflict_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rd_conflict |-> rd_stall);
  // R9: never two conflict marks in consecutive cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_conflict |=> !rd_conflict);
  // R8: a stall only exists while a write is in progress
  a_r8_stall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> wr_active);
  // R6: unmapped reads are never held back
  a_r6_hole_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hole |-> rd_ready);
endmodule

// File: rtl/flash_panel_mapper.sv
module flash_panel_mapper
  import fpm_pkg::*;
#(
  parameter int PANEL_AW   = 19,
  parameter int PAGE_AW    = 12,
  parameter int BOOT_PAGES = 16,
  localparam int BOOT_AW   = PAGE_AW + $clog2(BOOT_PAGES),
  localparam int AW        = PANEL_AW + 2,
  localparam int OFF_W     = PANEL_AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_swap,
  input  logic             cfg_dual_boot,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_panel,
  output logic [OFF_W-1:0] rd_offset,
  output logic             rd_hole,
  output logic             rd_stall,
  output logic             rd_conflict,
  input  logic             wr_active,
  input  logic [AW-1:0]    wr_addr,
  output logic             wr_panel,
  output logic [OFF_W-1:0] wr_offset,
  output logic             wr_hole
);
  fpm_cfg_t cfg;

  fpm_cfg_shadow u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_active(wr_active),
    .swap_req (cfg_swap),
    .dual_req (cfg_dual_boot),
    .cfg      (cfg)
  );

  // port 0 = read path, port 1 = write path
  logic [AW-1:0]    map_addr  [2];
  logic             map_panel [2];
  logic [OFF_W-1:0] map_off   [2];
  logic             map_hole  [2];

  assign map_addr[0] = rd_addr;
  assign map_addr[1] = wr_addr;

  for (genvar p = 0; p < 2; p++) begin : g_map
    fpm_addr_map #(.PANEL_AW(PANEL_AW), .BOOT_AW(BOOT_AW)) u_map (
      .addr  (map_addr[p]),
      .cfg   (cfg),
      .panel (map_panel[p]),
      .offset(map_off[p]),
      .hole  (map_hole[p])
    );
  end

  assign rd_panel  = map_panel[0];
  assign rd_offset = map_off[0];
  assign rd_hole   = map_hole[0];
  assign wr_panel  = map_panel[1];
  assign wr_offset = map_off[1];
  assign wr_hole   = map_hole[1];

  fpm_live_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .rd_panel   (map_panel[0]),
    .rd_hole    (map_hole[0]),
    .wr_active  (wr_active),
    .wr_panel   (map_panel[1]),
    .wr_hole    (map_hole[1]),
    .rd_ready   (rd_ready),
    .rd_stall   (rd_stall),
    .rd_conflict(rd_conflict)
  );

  // R7: an accepted read during a write never shares the written panel
  a_r7_no_shared_panel: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && wr_active && !rd_hole && !wr_hole)
      |-> (rd_panel != wr_panel));
  // R8: a held read keeps its mapping while the requester holds the address
  a_r8_map_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stall && wr_active && $stable(rd_addr)) |=>
      ($stable(rd_addr) -> $stable(rd_panel)));
endmodule

// File: tb/flash_panel_mapper_tb.sv
module flash_panel_mapper_tb;
  localparam int PA = 19;
  localparam int BA = 16;
  localparam int AW = PA + 2;
  localparam int OW = PA + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_swap = 1'b0, cfg_dual_boot = 1'b0;
  logic rd_valid = 1'b0, wr_active = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic rd_ready, rd_panel, rd_hole, rd_stall, rd_conflict;
  logic wr_panel, wr_hole;
  logic [OW-1:0] rd_offset, wr_offset;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_panel_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_swap(cfg_swap), .cfg_dual_boot(cfg_dual_boot),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_panel(rd_panel), .rd_offset(rd_offset), .rd_hole(rd_hole),
    .rd_stall(rd_stall), .rd_conflict(rd_conflict),
    .wr_active(wr_active), .wr_addr(wr_addr), .wr_panel(wr_panel),
    .wr_offset(wr_offset), .wr_hole(wr_hole)
  );

  function automatic logic [AW-1:0] prog_a(input logic lp, input logic [PA-1:0] off);
    return {1'b0, lp, off};
  endfunction

  function automatic logic [AW-1:0] boot_a(input logic [2:0] gap, input logic sel,
                                           input logic [BA-1:0] off);
    return {1'b1, gap, sel, off};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic set_cfg(input logic s, input logic d);
    @(negedge clk);
    wr_active = 1'b0; cfg_swap = s; cfg_dual_boot = d;
    settle();
  endtask

  task automatic idle();
    @(negedge clk);
    rd_valid = 1'b0; wr_active = 1'b0;
  endtask

  task automatic t_reset();
    cfg_swap = 1'b1; cfg_dual_boot = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; cfg_swap = 1'b0; cfg_dual_boot = 1'b0;
    rd_addr = prog_a(1'b0, 19'h00010);
    #1;
    chk("R1", "ready idle", rd_ready, 1);
    chk("R1", "stall idle", rd_stall, 0);
    chk("R1", "conflict idle", rd_conflict, 0);
    chk("R1", "swap cleared", rd_panel, 0);
    rd_addr = boot_a(3'b000, 1'b1, 16'h0000);
    #1 chk("R1", "single boot cleared", rd_panel, 1);
  endtask

  task automatic t_prog_map();
    set_cfg(1'b0, 1'b0);
    rd_addr = prog_a(1'b0, 19'h12345); #1;
    chk("R2", "panel lp0", rd_panel, 0);
    chk("R2", "offset lp0", rd_offset, {1'b0, 19'h12345});
    rd_addr = prog_a(1'b1, 19'h7FFFF); #1;
    chk("R2", "panel lp1", rd_panel, 1);
    chk("R2", "offset lp1", rd_offset, {1'b0, 19'h7FFFF});
    chk("R2", "no hole", rd_hole, 0);
  endtask

  task automatic t_swap();
    @(negedge clk);
    cfg_swap = 1'b1;
    rd_addr = prog_a(1'b0, 19'h7FFFF); #1;
    chk("R10", "swap not yet applied", rd_panel, 0);
    settle();
    chk("R3", "last low byte panel", rd_panel, 1);
    chk("R3", "last low byte offset", rd_offset, {1'b0, 19'h7FFFF});
    rd_addr = prog_a(1'b1, 19'h00000); #1;
    chk("R3", "first high byte panel", rd_panel, 0);
    chk("R3", "first high byte offset", rd_offset, 20'h0);
  endtask

  task automatic t_boot_single();
    set_cfg(1'b1, 1'b0);
    rd_addr = boot_a(3'b000, 1'b0, 16'hBEEF); #1;
    chk("R4", "single half0 panel", rd_panel, 0);
    chk("R4", "boot offset", rd_offset, {1'b1, 3'b000, 16'hBEEF});
    rd_addr = boot_a(3'b000, 1'b1, 16'hFFFF); #1;
    chk("R4", "single half1 panel", rd_panel, 1);
    chk("R4", "single half1 offset", rd_offset, {1'b1, 3'b000, 16'hFFFF});
  endtask

  task automatic t_boot_dual();
    set_cfg(1'b1, 1'b1);
    rd_addr = boot_a(3'b000, 1'b0, 16'h0042); #1;
    chk("R5", "dual swap half0", rd_panel, 1);
    rd_addr = boot_a(3'b000, 1'b1, 16'h0042); #1;
    chk("R5", "dual swap half1", rd_panel, 0);
    set_cfg(1'b0, 1'b1);
    rd_addr = boot_a(3'b000, 1'b0, 16'h0042); #1;
    chk("R5", "dual noswap half0", rd_panel, 0);
    chk("R5", "dual offset", rd_offset, {1'b1, 3'b000, 16'h0042});
  endtask

  task automatic t_hole();
    set_cfg(1'b0, 1'b0);
    wr_addr = boot_a(3'b000, 1'b0, 16'h0);
    wr_active = 1'b1;
    rd_addr = boot_a(3'b001, 1'b0, 16'h0); rd_valid = 1'b1; #1;
    chk("R6", "hole flag", rd_hole, 1);
    chk("R6", "hole ready", rd_ready, 1);
    chk("R6", "hole no conflict", rd_conflict, 0);
    rd_addr = boot_a(3'b100, 1'b0, 16'h0); #1;
    chk("R6", "top gap bit hole", rd_hole, 1);
    rd_addr = boot_a(3'b000, 1'b0, 16'h0); #1;
    chk("R6", "mapped boot not hole", rd_hole, 0);
    idle();
  endtask

  task automatic t_live();
    set_cfg(1'b0, 1'b0);
    wr_addr = prog_a(1'b1, 19'h00100); wr_active = 1'b1;
    rd_addr = prog_a(1'b0, 19'h00100); rd_valid = 1'b1; #1;
    chk("R7", "other panel ready", rd_ready, 1);
    chk("R7", "other panel no stall", rd_stall, 0);
    rd_addr = boot_a(3'b000, 1'b0, 16'h10); #1;
    chk("R7", "boot read other panel ready", rd_ready, 1);
    idle();
  endtask

  task automatic t_stall();
    set_cfg(1'b0, 1'b0);
    wr_addr = prog_a(1'b0, 19'h00200); wr_active = 1'b1;
    rd_addr = prog_a(1'b0, 19'h00300); rd_valid = 1'b1; #1;
    chk("R8", "same panel stall", rd_stall, 1);
    chk("R8", "same panel not ready", rd_ready, 0);
    chk("R9", "conflict first cycle", rd_conflict, 1);
    @(negedge clk); cfg_swap = 1'b1; #1;
    chk("R9", "conflict second cycle", rd_conflict, 0);
    chk("R8", "still stalled", rd_stall, 1);
    settle();
    chk("R10", "swap held during write", rd_panel, 0);
    chk("R8", "stalled third cycle", rd_ready, 0);
    @(negedge clk); wr_active = 1'b0; #1;
    chk("R8", "ready when write drops", rd_ready, 1);
    chk("R8", "mapping kept at issue", rd_panel, 0);
    settle();
    chk("R10", "held swap applied", rd_panel, 1);
    @(negedge clk); wr_active = 1'b1; wr_addr = prog_a(1'b0, 19'h0); #1;
    chk("R9", "new episode conflicts again", rd_conflict, 1);
    idle();
  endtask

  task automatic t_write_map();
    set_cfg(1'b1, 1'b0);
    wr_addr = prog_a(1'b0, 19'h0ABCD); #1;
    chk("R11", "write panel swapped", wr_panel, 1);
    chk("R11", "write offset", wr_offset, {1'b0, 19'h0ABCD});
    wr_addr = boot_a(3'b010, 1'b1, 16'h1); #1;
    chk("R11", "write hole", wr_hole, 1);
    set_cfg(1'b1, 1'b1);
    wr_addr = boot_a(3'b000, 1'b1, 16'h1234); #1;
    chk("R11", "write dual boot panel", wr_panel, 0);
    chk("R11", "write boot offset", wr_offset, {1'b1, 3'b000, 16'h1234});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_prog_map();
    t_swap();
    t_boot_single();
    t_boot_dual();
    t_hole();
    t_live();
    t_stall();
    t_write_map();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule